// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the command/address side of a large-page NAND flash device. A client hands it either one command byte, or an address mode together with a byte offset into the device. The block then produces the matching series of latch cycles on an 8-bit output bus. Command bytes are latched with the command strobe (`cle`) high and address bytes with the address strobe (`ale`) high. Each byte is clocked into the device by a write-enable low pulse. Once the last byte is out, both strobes drop and the block waits for the device's ready/busy line before it reports completion.

A column address is taken from bits 10:0 of the offset and a row (page) address from bits 18:11 and upward. A flag for the spare area can be merged into the second column byte, and its bit position depends on the device bus width. A third row byte is sent only for devices above 128 MiB. When the command is the device reset code, the block follows it on its own with a status command. It then reads the status byte through a read-enable strobe until the device reports ready.

The request side is a valid/ready pair. `req_ready` is the inverse of `busy`. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The client holds the request fields stable in that cycle, and there is no queueing. `done` pulses for one cycle at completion, and `busy` is low from the next cycle on.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request is accepted only when `busy` is low and `req_kind` is 0 to 4. A request presented while busy, or with kind 5 to 7, has no effect: no latch cycle, and `busy` is unchanged.
- R2: Kind 0 (command) emits exactly one latch cycle with `cle`=1, `ale`=0, and `io_out` equal to `req_cmd`.
- R3: For kinds 1 (column), 3 (column+page) and 4 (spare), the first two address bytes are offset[7:0], then {5'b0, offset[10:8]} (the spare flag is added on top in kind 4).
- R4: In kind 4 the second column byte also has bit 3 set when BUS16=0, or bit 2 set when BUS16=1.
- R5: Row bytes follow any column bytes in the order offset[18:11], offset[26:19], and then offset[34:27] only when BIG_DEV=1. Kind 2 (page) sends only row bytes.
- R6: Address byte counts are: kind 1 → 2; kind 2 → 2 (+1 if BIG_DEV); kinds 3 and 4 → 4 (+1 if BIG_DEV).
- R7: `cle` and `ale` are never high together. Every address byte is latched with `ale`=1 and `cle`=0. Both are low while idle, during status reads and while waiting for ready.
- R8: Every write-enable pulse is low for exactly WE_LOW clocks and then high for at least one clock, and `io_out` does not change at the rising edge.
- R9: After command 8'hFF, a status command 8'h70 is latched. `re_n` then pulses low for WE_LOW clocks per read, and reads repeat until `sts_data` bit 6 is 1 at the last low clock. No other bit of `sts_data` matters.
- R10: After the last latch cycle (or the ready status read), `busy` stays high while `rb_n` is 0. `done` pulses in a cycle with `rb_n`=1, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (inverse of busy) |
| req_kind | input | 3 | 0 command, 1 column, 2 page, 3 column+page, 4 spare |
| req_cmd | input | 8 | Command byte for kind 0 |
| req_offset | input | 35 | Byte offset for address kinds |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable for status, active low |
| io_out | output | 8 | Command/address byte bus |
| sts_data | input | 8 | Status byte from device |
| rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The hardest case to reach from the ports is a reset whose status poll has to go around several times. It must also show that only bit 6 ends the poll. The bench makes the status input return a byte with every bit set except bit 6 until a chosen number of reads has been seen, and checks that exactly that number plus one reads occur. A second instance with the other bus width and device size receives the same stimulus in lock step, so both spare-bit positions and both address lengths are covered by one offset sweep. The sweep walks a single set bit through every offset bit and adds pseudo-random offsets.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int OFS_W     = 35;
  localparam int MAX_BYTES = 5;

  typedef enum logic [2:0] {
    K_CMD     = 3'd0,
    K_COL     = 3'd1,
    K_PAGE    = 3'd2,
    K_COLPAGE = 3'd3,
    K_SPARE   = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SEND,
    S_STSRD,
    S_WAIT
  } seq_state_e;
endpackage

// File: rtl/nand_addr_fmt.sv
module nand_addr_fmt
  import nand_seq_pkg::*;
#(
  parameter bit BUS16   = 1'b0,
  parameter bit BIG_DEV = 1'b1
) (
  input  req_kind_e                   kind,
  input  logic [OFS_W-1:0]            ofs,
  output logic [MAX_BYTES-1:0][7:0]   bytes,
  output logic [2:0]                  count
);
  localparam int SPARE_BIT = BUS16 ? 2 : 3;
  localparam int ROW_CYC   = BIG_DEV ? 3 : 2;

  logic [2:0][7:0] row;
  logic [7:0]      col_hi;
  logic            use_col, use_row;
  int              base;

  assign row[0] = ofs[18:11];
  assign row[1] = ofs[26:19];
  assign row[2] = ofs[34:27];

  always_comb begin
    col_hi = {5'b0, ofs[10:8]};
    if (kind == K_SPARE) col_hi[SPARE_BIT] = 1'b1;
  end

  assign use_col = (kind == K_COL) || (kind == K_COLPAGE) || (kind == K_SPARE);
  assign use_row = (kind == K_PAGE) || (kind == K_COLPAGE) || (kind == K_SPARE);

  always_comb begin
    bytes = '0;
    base  = 0;
    if (use_col) begin
      bytes[0] = ofs[7:0];
      bytes[1] = col_hi;
      base     = 2;
    end
    if (use_row) begin
      for (int j = 0; j < ROW_CYC; j++) bytes[base+j] = row[j];
    end
    count = 3'(base + (use_row ? ROW_CYC : 0));
  end
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int LOW_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic low,
  output logic sample,
  output logic phase_end
);
  localparam int CW = $clog2(LOW_CLKS + 1);

  logic [CW-1:0] cnt;

  assign low       = run && (cnt < CW'(LOW_CLKS));
  assign sample    = run && (cnt == CW'(LOW_CLKS - 1));
  assign phase_end = run && (cnt == CW'(LOW_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || phase_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int       WE_LOW     = 2,
  parameter bit       BUS16      = 1'b0,
  parameter bit       BIG_DEV    = 1'b1,
  parameter bit [7:0] CMD_RESET  = 8'hFF,
  parameter bit [7:0] CMD_STATUS = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [7:0]       req_cmd,
  input  logic [OFS_W-1:0] req_offset,
  output logic             busy,
  output logic             done,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  input  logic [7:0]       sts_data,
  input  logic             rb_n
);
  seq_state_e                 state;
  req_kind_e                  kind;
  logic [MAX_BYTES-1:0][7:0]  fmt_bytes, byte_q;
  logic [2:0]                 fmt_count, nb, idx;
  logic                       cle_mode, rst_pend, sts_pend, sts_ok;
  logic                       t_low, t_sample, t_end, t_run;
  logic                       accept;

  assign kind = req_kind_e'(req_kind);

  nand_addr_fmt #(.BUS16(BUS16), .BIG_DEV(BIG_DEV)) fmt_i (
    .kind  (kind),
    .ofs   (req_offset),
    .bytes (fmt_bytes),
    .count (fmt_count)
  );

  assign t_run = (state == S_SEND) || (state == S_STSRD);

  nand_phase_timer #(.LOW_CLKS(WE_LOW)) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (t_run),
    .low       (t_low),
    .sample    (t_sample),
    .phase_end (t_end)
  );

  assign busy      = (state != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && !busy && (req_kind <= 3'd4);
  assign done      = (state == S_WAIT) && rb_n;
  assign cle       = (state == S_SEND) && cle_mode;
  assign ale       = (state == S_SEND) && !cle_mode;
  assign we_n      = !((state == S_SEND) && t_low);
  assign re_n      = !((state == S_STSRD) && t_low);
  assign io_out    = (state == S_SEND) ? byte_q[idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      byte_q   <= '0;
      nb       <= '0;
      idx      <= '0;
      cle_mode <= 1'b0;
      rst_pend <= 1'b0;
      sts_pend <= 1'b0;
      sts_ok   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            idx      <= '0;
            sts_pend <= 1'b0;
            state    <= S_SEND;
            if (kind == K_CMD) begin
              byte_q    <= '0;
              byte_q[0] <= req_cmd;
              nb        <= 3'd1;
              cle_mode  <= 1'b1;
              rst_pend  <= (req_cmd == CMD_RESET);
            end else begin
              byte_q   <= fmt_bytes;
              nb       <= fmt_count;
              cle_mode <= 1'b0;
              rst_pend <= 1'b0;
            end
          end
        end
        S_SEND: begin
          if (t_end) begin
            if (idx == nb - 1'b1) begin
              if (rst_pend) begin
                byte_q[0] <= CMD_STATUS;
                nb        <= 3'd1;
                idx       <= '0;
                rst_pend  <= 1'b0;
                sts_pend  <= 1'b1;
              end else if (sts_pend) begin
                state <= S_STSRD;
              end else begin
                state <= S_WAIT;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_STSRD: begin
          if (t_sample) sts_ok <= sts_data[6];
          if (t_end && sts_ok) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rb_n) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       busy,
  input logic       done,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic [7:0] io_out,
  input logic       rb_n
);
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cle && !ale && we_n && re_n));

  a_r8_io_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $stable(io_out));

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_kind <= 3'd4) |=> busy);

  a_r1_reject_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_kind <= 3'd4)) |=> !busy);

  a_r9_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!cle && !ale && we_n));

  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rb_n && busy));

  a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .busy      (busy),
  .done      (done),
  .cle       (cle),
  .ale       (ale),
  .we_n      (we_n),
  .re_n      (re_n),
  .io_out    (io_out),
  .rb_n      (rb_n)
);

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WL         = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [7:0]  req_cmd = '0;
  logic [34:0] req_offset = '0;
  logic [7:0]  sts_data;
  logic        rb_n = 1'b1;

  logic        rdy_a, busy_a, done_a, cle_a, ale_a, we_a, re_a;
  logic        rdy_b, busy_b, done_b, cle_b, ale_b, we_b, re_b;
  logic [7:0]  io_a, io_b;

  int total = 0, fails = 0, cycles = 0;
  int goal = 0;
  int rd_a = 0, rd_b = 0, na = 0, nb = 0;
  logic [9:0] log_a [0:15];
  logic [9:0] log_b [0:15];
  int lowcnt = 0;
  bit dseen_a = 0, dseen_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq #(.WE_LOW(WL), .BUS16(1'b0), .BIG_DEV(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
    .req_kind(req_kind), .req_cmd(req_cmd), .req_offset(req_offset),
    .busy(busy_a), .done(done_a), .cle(cle_a), .ale(ale_a), .we_n(we_a),
    .re_n(re_a), .io_out(io_a), .sts_data(sts_data), .rb_n(rb_n));

  nand_cmd_seq #(.WE_LOW(WL), .BUS16(1'b1), .BIG_DEV(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
    .req_kind(req_kind), .req_cmd(req_cmd), .req_offset(req_offset),
    .busy(busy_b), .done(done_b), .cle(cle_b), .ale(ale_b), .we_n(we_b),
    .re_n(re_b), .io_out(io_b), .sts_data(sts_data), .rb_n(rb_n));

  // R9: only bit 6 signals ready; all other bits set while not ready
  assign sts_data = (rd_a >= goal) ? 8'h40 : 8'hBF;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge we_a) if (rst_n) begin
    if (na < 16) log_a[na] = {cle_a, ale_a, io_a};
    na++;
  end
  always @(posedge we_b) if (rst_n) begin
    if (nb < 16) log_b[nb] = {cle_b, ale_b, io_b};
    nb++;
  end
  always @(posedge re_a) if (rst_n) rd_a++;
  always @(posedge re_b) if (rst_n) rd_b++;

  always @(posedge clk) begin
    if (done_a) dseen_a = 1;
    if (done_b) dseen_b = 1;
  end

  // R8: write-enable low width
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "WDOG", "watchdog expired", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (!we_a) lowcnt++;
      else if (lowcnt != 0) begin
        chk(lowcnt == WL, "R8", "we_n low width", lowcnt, WL);
        lowcnt = 0;
      end
    end
  end

  function automatic int exp_n(int k, bit big);
    if (k == 0) return 1;
    if (k == 1) return 2;
    if (k == 2) return big ? 3 : 2;
    return big ? 5 : 4;
  endfunction

  function automatic logic [7:0] exp_b(int k, logic [34:0] o, int i, bit b16, bit big);
    logic [7:0] q [0:4];
    logic [7:0] c1;
    int n = 0;
    for (int j = 0; j < 5; j++) q[j] = 8'h00;
    if (k == 1 || k == 3 || k == 4) begin
      c1 = {5'b0, o[10:8]};
      if (k == 4) c1 = c1 | (b16 ? 8'h04 : 8'h08);
      q[0] = o[7:0];
      q[1] = c1;
      n = 2;
    end
    if (k >= 2) begin
      q[n]   = o[18:11];
      q[n+1] = o[26:19];
      if (big) q[n+2] = o[34:27];
    end
    return q[i];
  endfunction

  function automatic string tag_of(int k, int i);
    bit has_col = (k == 1 || k == 3 || k == 4);
    if (has_col && i == 1 && k == 4) return "R4";
    if (has_col && i < 2) return "R3";
    return "R5";
  endfunction

  task automatic check_log(int k, logic [34:0] o, bit b16, bit big,
                           ref logic [9:0] lg [0:15], input int cnt);
    int en = exp_n(k, big);
    chk(cnt == en, "R6", "latch cycle count", cnt, en);
    for (int i = 0; i < en && i < cnt; i++) begin
      chk(lg[i][7:0] == exp_b(k, o, i, b16, big), tag_of(k, i), "address byte",
          lg[i][7:0], exp_b(k, o, i, b16, big));
      chk(lg[i][9:8] == 2'b01, "R7", "ale-only strobe on address", lg[i][9:8], 2'b01);
    end
  endtask

  // run one request on both instances; nreads = failing status reads before ready
  task automatic do_op(int k, logic [7:0] cmd, logic [34:0] o, int nreads);
    int ea, eb, erd;
    bit is_rst = (k == 0) && (cmd == 8'hFF);
    ea  = (k == 0) ? (is_rst ? 2 : 1) : exp_n(k, 1'b1);
    eb  = (k == 0) ? (is_rst ? 2 : 1) : exp_n(k, 1'b0);
    erd = is_rst ? nreads + 1 : 0;
    @(negedge clk);
    na = 0; nb = 0; rd_a = 0; rd_b = 0; goal = nreads;
    dseen_a = 0; dseen_b = 0;
    rb_n = 1'b0;
    req_valid = 1'b1; req_kind = 3'(k); req_cmd = cmd; req_offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 400; t++) begin
      if (na >= ea && nb >= eb && rd_a >= erd && rd_b >= erd) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    // R1: request while busy is ignored
    req_valid = 1'b1; req_kind = 3'd0; req_cmd = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy_a && busy_b, "R10", "busy held while rb_n low", {busy_a, busy_b}, 2'b11);
    rb_n = 1'b1;
    for (int t = 0; t < 10; t++) begin
      if (dseen_a && dseen_b) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk(dseen_a && dseen_b, "R10", "done pulse after ready", {dseen_a, dseen_b}, 2'b11);
    chk(!busy_a && !busy_b, "R10", "busy released after done", {busy_a, busy_b}, 2'b00);
    chk(rd_a == erd && rd_b == erd, "R9", "status read count", rd_a, erd);
    if (k == 0) begin
      chk(na == ea && nb == eb, "R1", "latch count (busy request ignored)", na, ea);
      chk(log_a[0] == {2'b10, cmd} && log_b[0] == {2'b10, cmd}, "R2",
          "command byte with cle", log_a[0], {2'b10, cmd});
      if (is_rst)
        chk(log_a[1] == {2'b10, 8'h70} && log_b[1] == {2'b10, 8'h70}, "R9",
            "status command after reset", log_a[1], {2'b10, 8'h70});
    end else begin
      check_log(k, o, 1'b0, 1'b1, log_a, na);
      check_log(k, o, 1'b1, 1'b0, log_b, nb);
    end
  endtask

  initial begin
    logic [34:0] lcg;
    repeat (3) @(negedge clk);
    chk(!busy_a && !busy_b && rdy_a && !done_a && !cle_a && !ale_a && we_a && re_a,
        "R7", "reset state quiet", {busy_a, cle_a, ale_a, we_a, re_a}, 5'b00011);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: illegal kinds are not accepted
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = 3'(k);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(!busy_a && !busy_b && na == 0, "R1", "illegal kind ignored", busy_a, 0);
    end
    // R2: plain commands
    do_op(0, 8'h00, '0, 0);
    do_op(0, 8'h30, '0, 0);
    do_op(0, 8'h90, '0, 0);
    // R9: reset with varying poll lengths
    do_op(0, 8'hFF, '0, 0);
    do_op(0, 8'hFF, '0, 1);
    do_op(0, 8'hFF, '0, 4);
    // R3-style sweep: walking one through every offset bit, all kinds
    for (int k = 1; k <= 4; k++) begin
      for (int b = 0; b < 35; b++) do_op(k, 8'h00, 35'd1 << b, 0);
      do_op(k, 8'h00, {35{1'b1}}, 0);
      lcg = 35'h1234_5678;
      for (int r = 0; r < 16; r++) begin
        lcg = lcg * 35'd1103515245 + 35'd12345;
        do_op(k, 8'h00, lcg, 0);
      end
    end
    finish_run();
  end
endmodule